// File: doc/BRIEF.md
# Supervisor Mode and Preemption Controller

This block holds the privilege flag of a small paged-memory computer and produces the timer interrupt that forces a running user process back into the kernel. The flag, called SUPER here, selects the kernel memory map while high and the per-process map while low. The only way to set it is a CPU vector fetch, which happens on reset, interrupts and software traps. The kernel leaves supervisor mode in two stages. A read of the process-ID register region arms the exit. The flag then drops at the end of the next opcode-fetch cycle, so the instruction after the arming read, typically the return-from-interrupt, still runs with the kernel map.

A down-counter measures how long a user process has run. It counts ticks from one of three sources: every CPU cycle, every opcode fetch, or rising edges of a slow external tick that is synchronised inside the block. When the counter runs out it drives the active-low NMI output. In supervisor mode the counter is held at its preset and NMI is held released. A fired NMI stays low until the resulting vector fetch raises SUPER again.

The design assumes one system clock per CPU bus cycle. The vector-pull, opcode-fetch and PID-read inputs are qualifiers for the cycle that the next rising clock edge closes.

Mode states: `MODE_KERNEL` (both stages set), `MODE_ARMED` (exit armed, SUPER still high) and `MODE_USER` (both clear). Mode transitions are: any state to `MODE_KERNEL` on a vector pull; `MODE_KERNEL` to `MODE_ARMED` on a PID read; `MODE_ARMED` to `MODE_USER` on an opcode fetch. Timer states: `TMR_HOLD` (reloading the preset), `TMR_RUN` (counting) and `TMR_FIRED` (NMI low). Timer transitions are: any state to `TMR_HOLD` while SUPER is set now or after the edge; `TMR_HOLD` or `TMR_RUN` to `TMR_FIRED` on expiry, otherwise to `TMR_RUN`.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset SUPER is 1, nmi_n is 1 and the exit is not armed, so opcode fetches alone do not leave supervisor mode.
- R2: A cycle with vec_pull high makes SUPER 1 at the edge closing that cycle, from any state. No other input raises SUPER.
- R3: In supervisor mode, a cycle with pid_rd high arms the exit while SUPER stays 1. SUPER goes to 0 at the edge that closes the next cycle with op_fetch high, and not earlier.
- R4: Once SUPER is 0 it stays 0 until a vector pull. pid_rd and op_fetch have no effect in user mode.
- R5: A pid_rd while already armed has no effect. A vector pull while armed cancels the exit, so a later op_fetch leaves SUPER at 1 until a fresh pid_rd.
- R6: While SUPER is 1 the counter is reloaded from preset at every edge and nmi_n is 1, whatever the tick source does.
- R7: With tick_sel = 0 every cycle is a tick. For a preset P of 1 or more, nmi_n falls P edges after the edge at which SUPER fell. A preset of 0 makes nmi_n fall at the first edge after SUPER fell.
- R8: With tick_sel = 1 only cycles with op_fetch high are ticks. Cycles without op_fetch leave the remaining count unchanged.
- R9: With tick_sel = 2 each rising edge of ext_tick counts once, after two synchroniser stages. With tick_sel = 3 no ticks occur and nmi_n stays 1 except at a preset of 0.
- R10: Once nmi_n is 0 it stays 0 while SUPER is 0. It returns to 1 at the same edge at which SUPER becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one period per CPU bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_pull | input | 1 | Current cycle is an interrupt or reset vector fetch |
| op_fetch | input | 1 | Current cycle is an opcode fetch |
| pid_rd | input | 1 | Current cycle reads the process-ID register region |
| tick_sel | input | 2 | Tick source: 0 every cycle, 1 opcode fetches, 2 external tick edges, 3 none |
| ext_tick | input | 1 | Slow asynchronous tick input |
| preset | input | CNT_W | Timer reload value |
| super_o | output | 1 | 1 selects the supervisor memory map |
| nmi_n | output | 1 | Active-low preemption interrupt |

## Verification
The bench builds the block with an 8-bit counter and the default two synchroniser stages. With this width, presets from 0 to 15 let a full countdown, expiry and sticky-NMI release happen many times within a few thousand cycles. The same random run also mixes in vector pulls that land in every mode and timer state. The two-stage synchroniser makes the external-tick latency short enough for directed pulse trains to reach expiry.

// File: rtl/priv_pkg.sv
package priv_pkg;

    // Privilege sequencing: both stages set, exit armed, both clear.
    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_ARMED  = 2'd1,
        MODE_USER   = 2'd2
    } mode_e;

    // Tick source encoding; the values are visible on the tick_sel port.
    typedef enum logic [1:0] {
        TSRC_CYCLE = 2'd0,
        TSRC_FETCH = 2'd1,
        TSRC_EXT   = 2'd2,
        TSRC_OFF   = 2'd3
    } tsrc_e;

    typedef enum logic [1:0] {
        TMR_HOLD  = 2'd0,
        TMR_RUN   = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_e;

endpackage

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import priv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vec_pull,
    input  logic op_fetch,
    input  logic pid_rd,
    output logic super_o,
    output logic super_nxt
);

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_KERNEL;
        end else begin
            state_q <= state_d;
        end
    end

    // A vector fetch overrides everything; otherwise a plain ladder.
    always_comb begin
        state_d = state_q;
        if (vec_pull) begin
            state_d = MODE_KERNEL;
        end else begin
            unique case (state_q)
                MODE_KERNEL: if (pid_rd)   state_d = MODE_ARMED;
                MODE_ARMED:  if (op_fetch) state_d = MODE_USER;
                MODE_USER:   state_d = MODE_USER;
                default:     state_d = MODE_KERNEL;
            endcase
        end
    end

    always_comb begin
        super_o   = (state_q != MODE_USER);
        super_nxt = (state_d != MODE_USER);
    end

    // R2: a vector pull always ends in supervisor mode
    a_r2_vec_enters: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull |=> super_o);

    // R2: supervisor mode is never entered without a vector pull
    a_r2_only_vec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(super_o) |-> $past(vec_pull));

    // R3: leaving needs the armed stage plus an opcode fetch
    a_r3_exit_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(super_o) |-> ($past(op_fetch) && $past(state_q == MODE_ARMED)));

    // R4: user mode is left only by a vector pull
    a_r4_user_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_USER && !vec_pull) |=> (state_q == MODE_USER));

    // R5: a repeated PID read while armed changes nothing
    a_r5_armed_pid_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_ARMED && pid_rd && !op_fetch && !vec_pull)
            |=> (state_q == MODE_ARMED));

endmodule

// File: rtl/pmc_tick_sel.sv
module pmc_tick_sel
    import priv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tick_sel,
    input  logic       op_fetch,
    input  logic       ext_tick,
    output logic       tick_en
);

    logic ext_sync;
    logic prev_q;
    logic ext_pulse;

    generate
        if (SYNC_STAGES < 2) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= ext_tick;
            end
            assign ext_sync = stage_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], ext_tick};
            end
            assign ext_sync = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ext_sync;
    end

    assign ext_pulse = ext_sync & ~prev_q;

    always_comb begin
        unique case (tsrc_e'(tick_sel))
            TSRC_CYCLE: tick_en = 1'b1;
            TSRC_FETCH: tick_en = op_fetch;
            TSRC_EXT:   tick_en = ext_pulse;
            TSRC_OFF:   tick_en = 1'b0;
            default:    tick_en = 1'b0;
        endcase
    end

    // R9: an external edge yields a single-cycle tick
    a_r9_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sel == 2'd2 && tick_en) |=> !(tick_sel == 2'd2 && tick_en));

endmodule

// File: rtl/pmc_preempt_timer.sv
module pmc_preempt_timer
    import priv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             super_now,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] preset,
    output logic             nmi_n
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_e             st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    assign expire = (cnt_q == '0) || (tick_en && cnt_q == CNT_ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TMR_HOLD;
            cnt_q <= preset;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (hold) begin
            st_d  = TMR_HOLD;
            cnt_d = preset;
        end else begin
            unique case (st_q)
                TMR_HOLD, TMR_RUN: begin
                    st_d = expire ? TMR_FIRED : TMR_RUN;
                    if (tick_en && cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
                end
                TMR_FIRED: st_d = TMR_FIRED;
                default:   st_d = TMR_HOLD;
            endcase
        end
    end

    always_comb begin
        nmi_n = (st_q != TMR_FIRED);
    end

    // R6: no interrupt request while the supervisor map is active
    a_r6_no_nmi_super: assert property (@(posedge clk) disable iff (!rst_n)
        super_now |-> nmi_n);

    // R6: a held edge leaves the counter at the preset
    a_r6_hold_preset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> (cnt_q == $past(preset)));

    // R10: a fired interrupt stays asserted in user mode
    a_r10_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_n && !hold) |=> !nmi_n);

    // R10: the interrupt releases on the edge that restores supervisor mode
    a_r10_nmi_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_n && hold) |=> nmi_n);

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import priv_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_pull,
    input  logic             op_fetch,
    input  logic             pid_rd,
    input  logic [1:0]       tick_sel,
    input  logic             ext_tick,
    input  logic [CNT_W-1:0] preset,
    output logic             super_o,
    output logic             nmi_n
);

    logic super_cur;
    logic super_nxt;
    logic tick_en;
    logic hold;

    pmc_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_pull  (vec_pull),
        .op_fetch  (op_fetch),
        .pid_rd    (pid_rd),
        .super_o   (super_cur),
        .super_nxt (super_nxt)
    );

    pmc_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_sel (tick_sel),
        .op_fetch (op_fetch),
        .ext_tick (ext_tick),
        .tick_en  (tick_en)
    );

    // Hold across both the entry edge and the exit edge.
    assign hold = super_cur | super_nxt;

    pmc_preempt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .super_now (super_cur),
        .tick_en   (tick_en),
        .preset    (preset),
        .nmi_n     (nmi_n)
    );

    assign super_o = super_cur;

endmodule

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;

    localparam int CW = 8;

    // 20-unit period: 50 MHz at 1 ns per unit
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, vec_pull, op_fetch, pid_rd, ext_tick;
    logic [1:0]    tick_sel;
    logic [CW-1:0] preset;
    logic          super_o, nmi_n;

    priv_mode_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .vec_pull(vec_pull), .op_fetch(op_fetch),
        .pid_rd(pid_rd), .tick_sel(tick_sel), .ext_tick(ext_tick),
        .preset(preset), .super_o(super_o), .nmi_n(nmi_n)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 kernel, 1 armed, 2 user.
    int m_mode;
    int m_cnt;
    bit m_nmi;
    bit s1, s2, pv;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit tick_of(input int sel, input bit fetch, input bit edge_seen);
        case (sel)
            0: return 1'b1;
            1: return fetch;
            2: return edge_seen;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step();
        int  nm;
        bit  tk;
        bit  hold;
        nm = m_mode;
        if (vec_pull)                  nm = 0;
        else if (m_mode == 0 && pid_rd)   nm = 1;
        else if (m_mode == 1 && op_fetch) nm = 2;
        hold = (m_mode != 2) || (nm != 2);
        tk = tick_of(int'(tick_sel), op_fetch, s2 & ~pv);
        if (hold) begin
            m_cnt = int'(preset);
            m_nmi = 1'b1;
        end else begin
            if (m_cnt == 0 || (tk && m_cnt == 1)) m_nmi = 1'b0;
            if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
        end
        pv = s2; s2 = s1; s1 = ext_tick;
        m_mode = nm;
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        if (rst_n) model_step();
        #5;
        chk({req, " super"}, int'(super_o), (m_mode != 2) ? 1 : 0);
        chk({req, " nmi"}, int'(nmi_n), int'(m_nmi));
    endtask

    task automatic idle();
        vec_pull = 0; pid_rd = 0; op_fetch = 0;
    endtask

    task automatic exit_seq();
        pid_rd = 1; cyc("R3");
        pid_rd = 0;
        chk("R3 armed keeps super", int'(super_o), 1);
        op_fetch = 1; cyc("R3");
        op_fetch = 0;
        chk("R3 exit after fetch", int'(super_o), 0);
    endtask

    task automatic enter_seq();
        vec_pull = 1; cyc("R2");
        vec_pull = 0;
        chk("R2 vector enters", int'(super_o), 1);
        chk("R10 release with entry", int'(nmi_n), 1);
    endtask

    initial begin
        int fired;
        int r;
        r = $urandom(32'd20231204);
        idle(); ext_tick = 0; tick_sel = 2'd0; preset = 8'd5; rst_n = 0;
        m_mode = 0; m_cnt = 5; m_nmi = 1; s1 = 0; s2 = 0; pv = 0;
        repeat (3) @(posedge clk);
        #5; rst_n = 1;
        chk("R1 reset super", int'(super_o), 1);
        chk("R1 reset nmi", int'(nmi_n), 1);

        // R1/R4: fetches without arming stay in supervisor
        op_fetch = 1;
        repeat (3) cyc("R1");
        op_fetch = 0;
        chk("R1 not armed", int'(super_o), 1);

        // R3: idle cycle between arming and the fetch keeps super
        pid_rd = 1; cyc("R3"); pid_rd = 0;
        cyc("R3");
        chk("R3 still super", int'(super_o), 1);
        op_fetch = 1; cyc("R3"); op_fetch = 0;
        chk("R3 dropped", int'(super_o), 0);

        // R7: countdown of 5 every-cycle ticks
        fired = 0;
        for (int k = 1; k <= 12; k++) begin
            if (k == 3) begin pid_rd = 1; op_fetch = 1; end   // R4: no effect in user
            if (k == 4) begin pid_rd = 0; op_fetch = 0; end
            cyc("R7");
            if (!nmi_n && fired == 0) fired = k;
        end
        chk("R7 latency P=5", fired, 5);
        chk("R4 user kept", int'(super_o), 0);
        chk("R10 nmi sticky", int'(nmi_n), 0);
        enter_seq();

        // R5: double PID read, then vector cancels
        pid_rd = 1; cyc("R5"); cyc("R5"); pid_rd = 0;
        chk("R5 armed super", int'(super_o), 1);
        vec_pull = 1; cyc("R5"); vec_pull = 0;
        op_fetch = 1; cyc("R5"); cyc("R5"); op_fetch = 0;
        chk("R5 exit cancelled", int'(super_o), 1);

        // R6: long kernel stay, ticking source active
        tick_sel = 2'd0; preset = 8'd3;
        repeat (30) cyc("R6");
        chk("R6 no nmi in kernel", int'(nmi_n), 1);

        // R8: fetch-counted ticks
        tick_sel = 2'd1;
        exit_seq();
        repeat (20) cyc("R8");
        chk("R8 idle cycles ignored", int'(nmi_n), 1);
        op_fetch = 1; cyc("R8"); cyc("R8");
        chk("R8 two fetches", int'(nmi_n), 1);
        cyc("R8"); op_fetch = 0;
        chk("R8 third fetch fires", int'(nmi_n), 0);
        enter_seq();

        // R9: no tick source, then external edges
        tick_sel = 2'd3; preset = 8'd2;
        exit_seq();
        repeat (40) cyc("R9");
        chk("R9 off source", int'(nmi_n), 1);
        tick_sel = 2'd2;
        for (int p = 0; p < 2; p++) begin
            ext_tick = 1; repeat (3) cyc("R9");
            ext_tick = 0; repeat (3) cyc("R9");
        end
        repeat (3) cyc("R9");
        chk("R9 two ext edges fire", int'(nmi_n), 0);
        enter_seq();

        // R7: zero preset fires at the first user edge
        tick_sel = 2'd3; preset = 8'd0;
        exit_seq();
        cyc("R7");
        chk("R7 preset zero", int'(nmi_n), 0);
        enter_seq();

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            if (n % 200 == 0) begin
                tick_sel = 2'($urandom % 4);
                preset   = CW'($urandom % 16);
            end
            vec_pull = ($urandom % 40) == 0;
            pid_rd   = ($urandom % 8) == 0;
            op_fetch = ($urandom % 3) == 0;
            if (($urandom % 5) == 0) ext_tick = ~ext_tick;
            cyc("R2 R3 R7 R10 random");
        end
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule